// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Watermark Interrupts

This block buffers stereo audio samples between a processor and a serial audio engine. It holds two sample queues of 32-bit words. The transmit queue is filled by software through a data write register and drained by the audio engine through a pop strobe. The receive queue is filled by the audio engine through a push strobe and drained by software through a data read register. Each queue tracks its occupancy with a separate counter.

Four interrupt sources watch the queues: transmit watermark, receive watermark, transmit empty and receive overflow. Each source has a latched state bit and an enable bit. Each source can also be forced through a test register. The watermark thresholds are chosen through small code tables, and the receive table falls back to a safe level for unused codes. Software clears the watermark and error sources either explicitly or as a side effect of its data reads and writes. A per-queue soft reset empties either queue in one cycle.

Register map (byte offsets): 0x00 interrupt state, 0x04 interrupt enable, 0x08 interrupt test, 0x0C control, 0x10 status, 0x14 read data, 0x18 write data, 0x1C queue control, 0x20 queue levels. In the three interrupt registers, bit 0 is the transmit watermark, bit 1 the receive watermark, bit 2 transmit empty and bit 3 receive overflow.

Top module: `audio_fifo_irq`

## Requirements
- R1: After reset both levels read 0, the status register (0x10) reads 0xC (bit 0 tx full, bit 1 rx full, bit 2 tx empty, bit 3 rx empty), all interrupt states and outputs are 0, and queue control (0x1C) reads 0x48 (rx code 2 in bits 4:2, tx code 2 in bits 6:5).
- R2: Each queue keeps 32 words in first-in first-out order. A push to a full queue is dropped and leaves its contents and count unchanged. The queue levels register (0x20) shows the tx count in bits 5:0 and the rx count in bits 21:16.
- R3: A data read (0x14) from an empty receive queue returns 0 and leaves the queue count unchanged.
- R4: The rx trigger code maps 0→1, 1→4, 2→8, 3→16 and 4→30 entries. Codes 5 to 7 are stored as code 2, which gives level 8.
- R5: The tx trigger code maps 0→1, 1→4, 2→8 and 3→16 entries.
- R6: The rx watermark state (bit 1) is set when a push leaves the rx count at or above the rx level. It is cleared when a data read leaves the count below that level.
- R7: The tx watermark state (bit 0) is set when a pop leaves the tx count below the tx level. It is cleared only when a data write leaves the count above that level.
- R8: A pop attempt on an empty tx queue sets tx empty (bit 2), and any data write clears it. A push to a full rx queue sets rx overflow (bit 3), and any data read clears it.
- R9: Writing 1 to a bit of the interrupt state register (0x00) clears that state. A write to the test register (0x08) forces all four states to the written bits, overriding any event in the same cycle. A hardware set wins over a clear in the same cycle.
- R10: Each interrupt output bit is high exactly when its state bit and its enable bit (0x04) are both 1.
- R11: Writing queue control with bit 0 set empties the rx queue, and with bit 1 set empties the tx queue. Either takes effect in one cycle, and the trigger codes of that write are stored as well.
- R12: Control bit 0 (0x0C) enables tx pops and control bit 1 enables rx pushes. While a bit is 0, the corresponding strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops rx on read data) |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| tx_pop_i | input | 1 | Audio engine takes one tx sample |
| tx_sample_o | output | 32 | Head of tx queue, 0 when empty |
| rx_push_i | input | 1 | Audio engine delivers one rx sample |
| rx_sample_i | input | 32 | Sample to push into rx queue |
| irq_o | output | 4 | Interrupt lines, state AND enable |

## Verification
On every cycle, the assertions check the occupancy bound and the one-cycle soft reset. They also check that a pop from an empty queue or a push to a full one leaves the count unchanged, that test writes win over events, and that overflow is set and tx-empty cleared by the right data events. They further check that the control bits gate the strobes and that the stored rx code is always legal. Only the bench's scenarios can show the threshold each trigger code produces. The same holds for the sample order across wrap-around, the exact count at which each watermark sets and clears (including the tx case where a write to exactly the level keeps the watermark set), and the fact that a dropped overflow sample never appears in the read stream.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;

  localparam int NUM_IRQ   = 4;
  localparam int IRQ_TXWM  = 0;
  localparam int IRQ_RXWM  = 1;
  localparam int IRQ_TXEMP = 2;
  localparam int IRQ_RXOVF = 3;

  localparam logic [5:0] OFF_STATE = 6'h00;
  localparam logic [5:0] OFF_EN    = 6'h04;
  localparam logic [5:0] OFF_TEST  = 6'h08;
  localparam logic [5:0] OFF_CTL   = 6'h0C;
  localparam logic [5:0] OFF_STAT  = 6'h10;
  localparam logic [5:0] OFF_RDATA = 6'h14;
  localparam logic [5:0] OFF_WDATA = 6'h18;
  localparam logic [5:0] OFF_FCTL  = 6'h1C;
  localparam logic [5:0] OFF_LVLS  = 6'h20;

  localparam logic [2:0] RX_CODE_DEFAULT = 3'd2;
  localparam logic [1:0] TX_CODE_DEFAULT = 2'd2;

  typedef logic [7:0] lvl_t;

  function automatic logic [2:0] rx_code_fix(input logic [2:0] code);
    return (code > 3'd4) ? RX_CODE_DEFAULT : code;
  endfunction

  function automatic lvl_t rx_level(input logic [2:0] code);
    case (code)
      3'd0:    return lvl_t'(1);
      3'd1:    return lvl_t'(4);
      3'd3:    return lvl_t'(16);
      3'd4:    return lvl_t'(30);
      default: return lvl_t'(8);
    endcase
  endfunction

  function automatic lvl_t tx_level(input logic [1:0] code);
    case (code)
      2'd0:    return lvl_t'(1);
      2'd1:    return lvl_t'(4);
      2'd2:    return lvl_t'(8);
      default: return lvl_t'(16);
    endcase
  endfunction

endpackage

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       push_i,
  input  logic [DW-1:0]              wdata_i,
  input  logic                       pop_i,
  output logic [DW-1:0]              rdata_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       full_o,
  output logic                       empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] mem_q [DEPTH];
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign count_o = cnt_q;
  assign rdata_o = empty_o ? '0 : mem_q[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (clr_i) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_d = ptr_inc(rd_ptr_q);
      cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !clr_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  // R2: occupancy never exceeds the depth
  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  // R2: push to a full queue alone leaves the count unchanged
  a_r2_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !clr_i) |=> $stable(cnt_q));
  // R3: pop from an empty queue alone leaves the count unchanged
  a_r3_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !clr_i) |=> (cnt_q == '0));
  // R11: soft reset empties the queue in one cycle
  a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);

endmodule

// File: rtl/audio_irq_bank.sv
module audio_irq_bank #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hw_set_i,
  input  logic [N-1:0] hw_clr_i,
  input  logic         w1c_we_i,
  input  logic [N-1:0] w1c_i,
  input  logic         test_we_i,
  input  logic [N-1:0] test_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] state_o,
  output logic [N-1:0] en_o,
  output logic [N-1:0] irq_o
);
  logic [N-1:0] state_q, state_d, en_q, en_d;

  always_comb begin
    state_d = state_q & ~hw_clr_i;
    if (w1c_we_i) state_d = state_d & ~w1c_i;
    state_d = state_d | hw_set_i;
    if (test_we_i) state_d = test_i;
    en_d = en_we_i ? en_i : en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      en_q    <= '0;
    end else begin
      state_q <= state_d;
      en_q    <= en_d;
    end
  end

  assign state_o = state_q;
  assign en_o    = en_q;
  assign irq_o   = state_q & en_q;

  // R9: a test write forces the latched states to the written bits
  a_r9_test_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_we_i |=> (state_q == $past(test_i)));
  // R9: with no events, a write-one-to-clear removes the selected bits
  a_r9_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w1c_we_i && !test_we_i && (hw_set_i == '0)) |=> ((state_q & $past(w1c_i)) == '0));

endmodule

// File: rtl/audio_fifo_irq.sv
module audio_fifo_irq
  import audio_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [5:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          tx_pop_i,
  output logic [DW-1:0] tx_sample_o,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_sample_i,
  output logic [3:0]    irq_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic wr_state, wr_en, wr_test, wr_ctl, wr_wdata, wr_fctl, rd_data;
  logic [1:0] ctl_q, ctl_d;
  logic [2:0] rx_code_q, rx_code_d;
  logic [1:0] tx_code_q, tx_code_d;

  logic          tx_pop, tx_clr, tx_full, tx_empty, tx_push_ok, tx_pop_ok;
  logic          rx_push, rx_clr, rx_full, rx_empty, rx_push_ok, rx_pop_ok;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [DW-1:0] rx_head;
  lvl_t          tx_cnt_nx, rx_cnt_nx, tx_lvl, rx_lvl;
  logic [NUM_IRQ-1:0] hw_set, hw_clr, irq_state, irq_en;

  assign wr_state = reg_we_i && (reg_addr_i == OFF_STATE);
  assign wr_en    = reg_we_i && (reg_addr_i == OFF_EN);
  assign wr_test  = reg_we_i && (reg_addr_i == OFF_TEST);
  assign wr_ctl   = reg_we_i && (reg_addr_i == OFF_CTL);
  assign wr_wdata = reg_we_i && (reg_addr_i == OFF_WDATA);
  assign wr_fctl  = reg_we_i && (reg_addr_i == OFF_FCTL);
  assign rd_data  = reg_re_i && (reg_addr_i == OFF_RDATA);

  // configuration registers
  always_comb begin
    ctl_d     = wr_ctl ? reg_wdata_i[1:0] : ctl_q;
    rx_code_d = wr_fctl ? rx_code_fix(reg_wdata_i[4:2]) : rx_code_q;
    tx_code_d = wr_fctl ? reg_wdata_i[6:5] : tx_code_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q     <= '0;
      rx_code_q <= RX_CODE_DEFAULT;
      tx_code_q <= TX_CODE_DEFAULT;
    end else begin
      ctl_q     <= ctl_d;
      rx_code_q <= rx_code_d;
      tx_code_q <= tx_code_d;
    end
  end

  assign tx_pop  = tx_pop_i && ctl_q[0];
  assign rx_push = rx_push_i && ctl_q[1];
  assign tx_clr  = wr_fctl && reg_wdata_i[1];
  assign rx_clr  = wr_fctl && reg_wdata_i[0];

  audio_sample_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(tx_clr),
    .push_i(wr_wdata), .wdata_i(reg_wdata_i[DW-1:0]), .pop_i(tx_pop),
    .rdata_o(tx_sample_o), .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
  );

  audio_sample_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(rx_clr),
    .push_i(rx_push), .wdata_i(rx_sample_i), .pop_i(rd_data),
    .rdata_o(rx_head), .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
  );

  // interrupt events
  always_comb begin
    tx_push_ok = wr_wdata && !tx_full;
    tx_pop_ok  = tx_pop && !tx_empty;
    rx_push_ok = rx_push && !rx_full;
    rx_pop_ok  = rd_data && !rx_empty;
    tx_cnt_nx  = lvl_t'(tx_cnt) + lvl_t'(tx_push_ok) - lvl_t'(tx_pop_ok);
    rx_cnt_nx  = lvl_t'(rx_cnt) + lvl_t'(rx_push_ok) - lvl_t'(rx_pop_ok);
    tx_lvl     = tx_level(tx_code_q);
    rx_lvl     = rx_level(rx_code_q);

    hw_set            = '0;
    hw_clr            = '0;
    hw_set[IRQ_TXWM]  = tx_pop_ok && (tx_cnt_nx < tx_lvl);
    hw_clr[IRQ_TXWM]  = wr_wdata && (tx_cnt_nx > tx_lvl);
    hw_set[IRQ_RXWM]  = rx_push_ok && (rx_cnt_nx >= rx_lvl);
    hw_clr[IRQ_RXWM]  = rd_data && (rx_cnt_nx < rx_lvl);
    hw_set[IRQ_TXEMP] = tx_pop && tx_empty;
    hw_clr[IRQ_TXEMP] = wr_wdata;
    hw_set[IRQ_RXOVF] = rx_push && rx_full;
    hw_clr[IRQ_RXOVF] = rd_data;
  end

  audio_irq_bank #(.N(NUM_IRQ)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hw_set_i(hw_set), .hw_clr_i(hw_clr),
    .w1c_we_i(wr_state), .w1c_i(reg_wdata_i[NUM_IRQ-1:0]),
    .test_we_i(wr_test), .test_i(reg_wdata_i[NUM_IRQ-1:0]),
    .en_we_i(wr_en), .en_i(reg_wdata_i[NUM_IRQ-1:0]),
    .state_o(irq_state), .en_o(irq_en), .irq_o(irq_o)
  );

  // register read mux
  always_comb begin
    case (reg_addr_i)
      OFF_STATE: reg_rdata_o = 32'(irq_state);
      OFF_EN:    reg_rdata_o = 32'(irq_en);
      OFF_CTL:   reg_rdata_o = 32'(ctl_q);
      OFF_STAT:  reg_rdata_o = 32'({rx_empty, tx_empty, rx_full, tx_full});
      OFF_RDATA: reg_rdata_o = 32'(rx_head);
      OFF_FCTL:  reg_rdata_o = 32'({tx_code_q, rx_code_q, 2'b00});
      OFF_LVLS:  reg_rdata_o = 32'(tx_cnt) | (32'(rx_cnt) << 16);
      default:   reg_rdata_o = '0;
    endcase
  end

  // R4: the stored rx code is always one of the five legal codes
  a_r4_rx_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_code_q <= 3'd4);
  // R8: a push into a full rx queue latches overflow
  a_r8_ovf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push && rx_full && !wr_test) |=> irq_state[IRQ_RXOVF]);
  // R8: a data write clears tx empty unless an empty pop coincides
  a_r8_txemp_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_wdata && !(tx_pop && tx_empty) && !wr_test) |=> !irq_state[IRQ_TXEMP]);
  // R12: with rx disabled and no read or reset, the rx count holds
  a_r12_rx_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_q[1] && !rd_data && !rx_clr) |=> $stable(rx_cnt));
  // R12: with tx disabled and no write or reset, the tx count holds
  a_r12_tx_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_q[0] && !wr_wdata && !tx_clr) |=> $stable(tx_cnt));

endmodule

// File: tb/audio_fifo_irq_tb_top.sv
module audio_fifo_irq_tb_top;

  logic        clk, rst_n;
  logic        we, re, tx_pop, rx_push;
  logic [5:0]  addr;
  logic [31:0] wdata, rdata, tx_sample, rx_sample;
  logic [3:0]  irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [5:0] A_STATE = 6'h00, A_EN = 6'h04, A_TEST = 6'h08, A_CTL = 6'h0C,
                         A_STAT = 6'h10, A_RD = 6'h14, A_WR = 6'h18, A_FCTL = 6'h1C,
                         A_LVLS = 6'h20;

  // direction (0 = rx, 1 = tx), trigger code, expected threshold
  localparam int NV = 12;
  localparam int VEC_DIR  [NV] = '{0, 0, 0, 0, 0,  0, 0, 0, 1, 1, 1, 1};
  localparam int VEC_CODE [NV] = '{0, 1, 2, 3, 4,  5, 6, 7, 0, 1, 2, 3};
  localparam int VEC_LVL  [NV] = '{1, 4, 8, 16, 30, 8, 8, 8, 1, 4, 8, 16};

  audio_fifo_irq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tx_pop_i(tx_pop), .tx_sample_o(tx_sample),
    .rx_push_i(rx_push), .rx_sample_i(rx_sample), .irq_o(irq)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    re = 1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    re = 0;
  endtask

  task automatic push_rx(input logic [31:0] d);
    @(negedge clk);
    rx_push = 1; rx_sample = d;
    @(negedge clk);
    rx_push = 0;
  endtask

  task automatic pop_tx(output logic [31:0] d);
    @(negedge clk);
    tx_pop = 1;
    #1 d = tx_sample;
    @(negedge clk);
    tx_pop = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int got, errs;
    rst_n = 0; we = 0; re = 0; tx_pop = 0; rx_push = 0;
    addr = '0; wdata = '0; rx_sample = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    reg_rd(A_LVLS, v);  chk("R1 levels", v, 32'h0);
    reg_rd(A_STAT, v);  chk("R1 status", v, 32'hC);
    reg_rd(A_STATE, v); chk("R1 irq state", v, 32'h0);
    chk("R1 irq out", 32'(irq), 32'h0);
    reg_rd(A_FCTL, v);  chk("R1 queue control", v, 32'h48);

    reg_wr(A_CTL, 32'h3);

    // R4 / R5: table of trigger codes and thresholds
    for (int i = 0; i < NV; i++) begin
      if (VEC_DIR[i] == 0) begin
        reg_wr(A_FCTL, (32'd2 << 5) | (32'(VEC_CODE[i]) << 2) | 32'h1);
        reg_wr(A_STATE, 32'hF);
        reg_wr(A_EN, 32'h2);
        got = -1;
        for (int k = 1; k <= 32; k++) begin
          push_rx(32'(k));
          if (got < 0 && irq[1]) got = k;
        end
        chk($sformatf("R4 rx code %0d threshold", VEC_CODE[i]), 32'(got), 32'(VEC_LVL[i]));
      end else begin
        reg_wr(A_FCTL, (32'(VEC_CODE[i]) << 5) | (32'd2 << 2) | 32'h2);
        for (int k = 0; k < 20; k++) reg_wr(A_WR, 32'(k));
        reg_wr(A_STATE, 32'hF);
        reg_wr(A_EN, 32'h1);
        got = -1;
        for (int p = 1; p <= 20; p++) begin
          pop_tx(v);
          if (got < 0 && irq[0]) got = 20 - p;
        end
        chk($sformatf("R5 tx code %0d count at set", VEC_CODE[i]), 32'(got), 32'(VEC_LVL[i] - 1));
      end
    end
    reg_rd(A_FCTL, v); chk("R4 fallback code stored as 2", (v >> 2) & 32'h7, 32'h2);

    // R11: soft reset of both queues in one write
    reg_wr(A_FCTL, 32'h48 | 32'h3);
    reg_rd(A_LVLS, v); chk("R11 levels after soft reset", v, 32'h0);

    // R12: disabled strobes are ignored
    reg_wr(A_CTL, 32'h0);
    reg_wr(A_WR, 32'hAA);
    pop_tx(v);
    push_rx(32'h55);
    reg_rd(A_LVLS, v); chk("R12 disabled pop and push ignored", v, 32'h1);
    reg_wr(A_CTL, 32'h3);

    // R3: read from empty rx queue
    reg_rd(A_RD, v);   chk("R3 empty read data", v, 32'h0);
    reg_rd(A_LVLS, v); chk("R3 empty read keeps levels", v, 32'h1);

    // R2: capacity, drop on full, order across wrap
    reg_wr(A_FCTL, 32'h48 | 32'h2);
    for (int k = 0; k < 33; k++) reg_wr(A_WR, 32'(100 + k));
    reg_rd(A_LVLS, v); chk("R2 tx level saturates at 32", v & 32'h3F, 32'd32);
    reg_rd(A_STAT, v); chk("R2 tx full flag", v & 32'h1, 32'h1);
    errs = 0;
    for (int k = 0; k < 32; k++) begin
      pop_tx(v);
      if (v !== 32'(100 + k)) errs++;
    end
    chk("R2 tx order", 32'(errs), 32'h0);

    // R8: tx empty set by pop on empty, cleared by write
    reg_wr(A_STATE, 32'hF);
    pop_tx(v);         chk("R8 pop on empty returns 0", v, 32'h0);
    reg_rd(A_STATE, v); chk("R8 tx empty set", v & 32'h4, 32'h4);
    reg_wr(A_WR, 32'h5);
    reg_rd(A_STATE, v); chk("R8 tx empty cleared by write", v & 32'h4, 32'h0);

    // R7: tx watermark with code 1 (level 4)
    reg_wr(A_FCTL, (32'd1 << 5) | (32'd2 << 2) | 32'h2);
    for (int k = 0; k < 5; k++) reg_wr(A_WR, 32'(k));
    reg_wr(A_STATE, 32'hF);
    pop_tx(v);
    reg_rd(A_STATE, v); chk("R7 no set at count 4", v & 32'h1, 32'h0);
    pop_tx(v);
    reg_rd(A_STATE, v); chk("R7 set at count 3", v & 32'h1, 32'h1);
    reg_wr(A_WR, 32'h9);
    reg_rd(A_STATE, v); chk("R7 kept at count 4", v & 32'h1, 32'h1);
    reg_wr(A_WR, 32'h9);
    reg_rd(A_STATE, v); chk("R7 cleared at count 5", v & 32'h1, 32'h0);

    // R6: rx watermark with code 1 (level 4)
    reg_wr(A_FCTL, (32'd2 << 5) | (32'd1 << 2) | 32'h1);
    reg_wr(A_STATE, 32'hF);
    for (int k = 0; k < 3; k++) push_rx(32'(50 + k));
    reg_rd(A_STATE, v); chk("R6 no set at count 3", v & 32'h2, 32'h0);
    push_rx(32'd53);
    reg_rd(A_STATE, v); chk("R6 set at count 4", v & 32'h2, 32'h2);
    reg_rd(A_RD, v);    chk("R6 read returns oldest", v, 32'd50);
    reg_rd(A_STATE, v); chk("R6 cleared at count 3", v & 32'h2, 32'h0);

    // R8 / R10 / R2: rx overflow, dropped sample
    reg_wr(A_FCTL, 32'h48 | 32'h1);
    for (int k = 0; k < 32; k++) push_rx(32'(200 + k));
    reg_wr(A_STATE, 32'hF);
    reg_wr(A_EN, 32'h8);
    push_rx(32'd999);
    chk("R10 overflow line with enable", 32'(irq), 32'h8);
    reg_rd(A_RD, v);    chk("R8 first read after overflow", v, 32'd200);
    reg_rd(A_STATE, v); chk("R8 overflow cleared by read", v & 32'h8, 32'h0);
    for (int k = 1; k < 32; k++) reg_rd(A_RD, v);
    chk("R2 overflow sample dropped", v, 32'd231);

    // R9 / R10: test force, write-one-to-clear, enable gating
    reg_wr(A_TEST, 32'hF);
    reg_rd(A_STATE, v); chk("R9 test forces states", v, 32'hF);
    reg_wr(A_STATE, 32'h5);
    reg_rd(A_STATE, v); chk("R9 w1c clears selected", v, 32'hA);
    reg_wr(A_EN, 32'h0);
    chk("R10 no line without enable", 32'(irq), 32'h0);
    reg_wr(A_EN, 32'h3);
    chk("R10 line equals state and enable", 32'(irq), 32'h2);

    done = 1;
    summary();
    $finish;
  end

endmodule